// File: doc/BRIEF.md
# Output Impedance Calibration Controller

This block holds two drive-strength codes for a programmable pad driver, one for the pull-up half and one for the pull-down half. Each code is a plain unsigned binary value, and each bit weights one binary step of driver strength. Supply and temperature drift slowly, so calibration never stops while the block is out of reset. A free-running interval counter raises an evaluation tick once every `INTERVAL` clock cycles. On that tick, each half reads its own comparator flags (increase or decrease) and forms a new code that is at most one step away from the code currently applied. Codes saturate at the ends of their range.

A new code must reach the driver only while that half of the driver is idle. The pull-up code may change only while the pad drives a 0 or is Hi-Z. The pull-down code may change only while the pad drives a 1 or is Hi-Z. When the pad state forbids the change, the new code waits as pending. It is released on the first cycle that the pad state allows.

Each half runs a two-state machine:
- SETTLED: nothing is waiting.
- PENDING: a computed code waits for the pad to go idle on that half.

The transitions are:
- EVAL_HOLD: on a tick whose step leaves the code unchanged, go to SETTLED and discard any pending value.
- EVAL_APPLY: on a tick with a changed code while the half is idle, apply the code at once and go to SETTLED.
- EVAL_DEFER: on a tick with a changed code while the half is busy, store it and go to PENDING. When this happens in PENDING, it overwrites the older pending value.
- RELEASE: in PENDING with no tick, once the half is idle, apply the pending code and go to SETTLED.

Top module: `zcal_ctrl`

## Requirements
- R1: While `rst_n` is low and after its release, both `pu_code` and `pd_code` equal 6'b100000 (32) until the first evaluation changes them.
- R2: An evaluation happens on every `INTERVAL`-th rising clock edge after reset release: edge number `INTERVAL`, then `2*INTERVAL`, and so on. A code changes only on an evaluation edge or when a pending value is released.
- R3: Between two consecutive cycles, an applied code changes by at most one step.
- R4: At an evaluation, increase alone raises the computed code by one. Decrease alone lowers it by one. Neither flag, or both flags together, leave it equal to the applied code.
- R5: Codes saturate: increase at 63 yields 63, decrease at 0 yields 0, and a code never wraps.
- R6: `pd_code` changes only at an edge where `pad_st` is 2'b01 (driving 1) or 2'b10 (Hi-Z).
- R7: `pu_code` changes only at an edge where `pad_st` is 2'b00 (driving 0) or 2'b10 (Hi-Z).
- R8: A deferred code is applied at the first later edge where the pad state allows it. A newer evaluation replaces the pending value; when the new step equals the applied code, nothing stays pending.
- R9: Pad state 2'b11 is reserved and lets neither code change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| pad_st | input | 2 | Present pad state: 00 drive 0, 01 drive 1, 10 Hi-Z, 11 reserved |
| pu_inc | input | 1 | Comparator asks for a stronger pull-up |
| pu_dec | input | 1 | Comparator asks for a weaker pull-up |
| pd_inc | input | 1 | Comparator asks for a stronger pull-down |
| pd_dec | input | 1 | Comparator asks for a weaker pull-down |
| pu_code | output | 6 | Applied pull-up strength code |
| pd_code | output | 6 | Applied pull-down strength code |

## Verification
A wrong interval count shows at the first evaluation edge: a code moves one cycle early or late, or skips a tick. A lost or stale pending value shows in the one cycle when the pad state first lets that half change; there the code either fails to move or moves to the wrong value. A saturation or step fault shows as a code at an end of range that wraps or jumps. A reference model that runs cycle by cycle catches each of these within one clock.

// File: rtl/zcal_pkg.sv
package zcal_pkg;

    typedef enum logic [1:0] {
        PAD_LOW  = 2'b00,
        PAD_HIGH = 2'b01,
        PAD_HIZ  = 2'b10,
        PAD_RSVD = 2'b11
    } pad_st_e;

    typedef enum logic {
        HS_SETTLED = 1'b0,
        HS_PENDING = 1'b1
    } half_st_e;

    localparam int HALF_PU = 0;
    localparam int HALF_PD = 1;
    localparam int N_HALF  = 2;

endpackage

// File: rtl/zcal_interval.sv
module zcal_interval #(
    parameter int INTERVAL = 1024
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam int CW = (INTERVAL > 1) ? $clog2(INTERVAL) : 1;
    localparam logic [CW-1:0] LAST = CW'(INTERVAL - 1);

    logic [CW-1:0] cnt_q;

    assign tick = (cnt_q == LAST);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (tick) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    generate
        if (INTERVAL > 1) begin : g_gap
            AST_TICK_GAP: assert property (@(posedge clk) disable iff (!rst_n)
                tick |=> !tick); // R2
        end
    endgenerate

endmodule

// File: rtl/zcal_half.sv
module zcal_half
    import zcal_pkg::*;
#(
    parameter int W = 6
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    input  logic         inc,
    input  logic         dec,
    input  logic         allow,
    output logic [W-1:0] code
);
    localparam logic [W-1:0] MID = {1'b1, {(W-1){1'b0}}};
    localparam logic [W-1:0] TOP = {W{1'b1}};

    half_st_e     st_q, st_d;
    logic [W-1:0] code_q, code_d;
    logic [W-1:0] pend_q, pend_d;
    logic [W-1:0] stepped;

    always_comb begin
        stepped = code_q;
        if (inc && !dec && code_q != TOP) begin
            stepped = code_q + 1'b1;
        end else if (dec && !inc && code_q != '0) begin
            stepped = code_q - 1'b1;
        end
    end

    always_comb begin
        st_d   = st_q;
        code_d = code_q;
        pend_d = pend_q;
        if (tick) begin
            if (stepped == code_q) begin
                st_d = HS_SETTLED;
            end else if (allow) begin
                code_d = stepped;
                st_d   = HS_SETTLED;
            end else begin
                pend_d = stepped;
                st_d   = HS_PENDING;
            end
        end else begin
            unique case (st_q)
                HS_SETTLED: ;
                HS_PENDING: begin
                    if (allow) begin
                        code_d = pend_q;
                        st_d   = HS_SETTLED;
                    end
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= HS_SETTLED;
        end else begin
            st_q <= st_d;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            code_q <= MID;
            pend_q <= MID;
        end else begin
            code_q <= code_d;
            pend_q <= pend_d;
        end
    end

    assign code = code_q;

    AST_ONE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (code_q != $past(code_q)) |->
            ((code_q - $past(code_q)) == W'(1) || ($past(code_q) - code_q) == W'(1))); // R3
    AST_NO_WRAP_UP: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(code_q) == TOP) |-> (code_q != '0)); // R5
    AST_NO_WRAP_DN: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(code_q) == '0) |-> (code_q != TOP)); // R5
    AST_SETTLED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == HS_SETTLED && !tick) |=> $stable(code_q)); // R2

endmodule

// File: rtl/zcal_ctrl.sv
module zcal_ctrl
    import zcal_pkg::*;
#(
    parameter int CODE_W   = 6,
    parameter int INTERVAL = 1024
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        pad_st,
    input  logic              pu_inc,
    input  logic              pu_dec,
    input  logic              pd_inc,
    input  logic              pd_dec,
    output logic [CODE_W-1:0] pu_code,
    output logic [CODE_W-1:0] pd_code
);
    logic                     tick;
    logic [N_HALF-1:0]        allow;
    logic [N_HALF-1:0]        inc;
    logic [N_HALF-1:0]        dec;
    logic [CODE_W-1:0]        code [N_HALF];

    zcal_interval #(.INTERVAL(INTERVAL)) u_interval (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick)
    );

    always_comb begin
        allow[HALF_PU] = (pad_st == PAD_LOW)  || (pad_st == PAD_HIZ);
        allow[HALF_PD] = (pad_st == PAD_HIGH) || (pad_st == PAD_HIZ);
        inc[HALF_PU]   = pu_inc;
        dec[HALF_PU]   = pu_dec;
        inc[HALF_PD]   = pd_inc;
        dec[HALF_PD]   = pd_dec;
    end

    generate
        for (genvar h = 0; h < N_HALF; h++) begin : g_half
            zcal_half #(.W(CODE_W)) u_half (
                .clk   (clk),
                .rst_n (rst_n),
                .tick  (tick),
                .inc   (inc[h]),
                .dec   (dec[h]),
                .allow (allow[h]),
                .code  (code[h])
            );
        end
    endgenerate

    assign pu_code = code[HALF_PU];
    assign pd_code = code[HALF_PD];

    AST_PD_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        (pd_code != $past(pd_code)) |->
            ($past(pad_st) == PAD_HIGH || $past(pad_st) == PAD_HIZ)); // R6
    AST_PU_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        (pu_code != $past(pu_code)) |->
            ($past(pad_st) == PAD_LOW || $past(pad_st) == PAD_HIZ)); // R7
    AST_RSVD_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
        (pad_st == PAD_RSVD) |=> ($stable(pu_code) && $stable(pd_code))); // R9

endmodule

// File: tb/test_zcal_ctrl.sv
module test_zcal_ctrl;
    localparam int IV   = 16;
    localparam int W    = 6;
    localparam int MAXV = 63;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [1:0]   pad_st = 2'b10;
    logic         pu_inc = 1'b0, pu_dec = 1'b0, pd_inc = 1'b0, pd_dec = 1'b0;
    logic [W-1:0] pu_code, pd_code;

    int n_chk = 0;
    int n_err = 0;
    bit done = 1'b0;

    int m_cnt = 0;
    int m_code [2];
    int m_pend [2];
    bit m_has  [2];

    always #2.5 clk = ~clk;

    zcal_ctrl #(.CODE_W(W), .INTERVAL(IV)) i_zcal_ctrl (
        .clk(clk), .rst_n(rst_n), .pad_st(pad_st),
        .pu_inc(pu_inc), .pu_dec(pu_dec), .pd_inc(pd_inc), .pd_dec(pd_dec),
        .pu_code(pu_code), .pd_code(pd_code)
    );

    function automatic int step_of(int c, bit up, bit dn);
        if (up && !dn) return (c < MAXV) ? c + 1 : c;
        if (dn && !up) return (c > 0) ? c - 1 : c;
        return c;
    endfunction

    function automatic bit may_apply(int half, logic [1:0] p);
        if (half == 0) return (p == 2'b00) || (p == 2'b10);
        return (p == 2'b01) || (p == 2'b10);
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_cnt = 0;
            for (int h = 0; h < 2; h++) begin
                m_code[h] = 32; m_pend[h] = 32; m_has[h] = 1'b0;
            end
        end else begin
            bit tk;
            tk = (m_cnt == IV - 1);
            m_cnt = tk ? 0 : m_cnt + 1;
            for (int h = 0; h < 2; h++) begin
                int s;
                bit ok;
                ok = may_apply(h, pad_st);
                s = (h == 0) ? step_of(m_code[h], pu_inc, pu_dec)
                             : step_of(m_code[h], pd_inc, pd_dec);
                if (tk) begin
                    if (s == m_code[h]) m_has[h] = 1'b0;
                    else if (ok) begin m_code[h] = s; m_has[h] = 1'b0; end
                    else begin m_pend[h] = s; m_has[h] = 1'b1; end
                end else if (m_has[h] && ok) begin
                    m_code[h] = m_pend[h];
                    m_has[h] = 1'b0;
                end
            end
        end
    end

    task automatic chk(bit ok, string tag, int act, int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic cmp_model(string tag);
        chk(int'(pu_code) == m_code[0], {tag, " pu_code model R2 R4 R7 R8"}, int'(pu_code), m_code[0]);
        chk(int'(pd_code) == m_code[1], {tag, " pd_code model R2 R4 R6 R8"}, int'(pd_code), m_code[1]);
    endtask

    task automatic cyc(logic [1:0] p, bit ui, bit ud, bit di, bit dd, string tag);
        pad_st = p; pu_inc = ui; pu_dec = ud; pd_inc = di; pd_dec = dd;
        @(negedge clk);
        cmp_model(tag);
    endtask

    task automatic to_tick(logic [1:0] p);
        while (m_cnt != IV - 1) cyc(p, 0, 0, 0, 0, "align");
    endtask

    initial begin
        #(5ns * 100000);
        n_err++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        int prev_pu;
        int prev_pd;
        void'($urandom(32'd20240601));
        repeat (3) @(negedge clk);
        chk(pu_code == 6'd32, "R1 pu reset", int'(pu_code), 32);
        chk(pd_code == 6'd32, "R1 pd reset", int'(pd_code), 32);
        rst_n = 1'b1;
        // R2: the first evaluation lands on edge IV after release
        for (int k = 1; k < IV; k++) cyc(2'b10, 1, 0, 0, 1, "R2 pre-tick");
        chk(pu_code == 6'd32, "R2 before first eval", int'(pu_code), 32);
        cyc(2'b10, 1, 0, 0, 1, "R2 tick");
        chk(pu_code == 6'd33, "R2 R4 pu inc", int'(pu_code), 33);
        chk(pd_code == 6'd31, "R2 R4 pd dec", int'(pd_code), 31);
        // R5: saturation at both ends
        repeat (40 * IV) cyc(2'b10, 1, 0, 0, 1, "R5 sat run");
        chk(pu_code == 6'd63, "R5 pu saturates high", int'(pu_code), 63);
        chk(pd_code == 6'd0, "R5 pd saturates low", int'(pd_code), 0);
        // R6 R8: pull-down deferred while driving 0
        to_tick(2'b00);
        cyc(2'b00, 0, 0, 1, 0, "R6 defer");
        chk(pd_code == 6'd0, "R6 pd held while low", int'(pd_code), 0);
        repeat (3) cyc(2'b00, 0, 0, 0, 0, "R6 wait");
        chk(pd_code == 6'd0, "R6 pd still held", int'(pd_code), 0);
        cyc(2'b01, 0, 0, 0, 0, "R8 release");
        chk(pd_code == 6'd1, "R8 pending applied", int'(pd_code), 1);
        // R8: newer evaluation overwrites pending
        to_tick(2'b00);
        cyc(2'b00, 0, 0, 0, 1, "R8 first pend");
        to_tick(2'b00);
        cyc(2'b00, 0, 0, 1, 0, "R8 second pend");
        chk(pd_code == 6'd1, "R8 pd held", int'(pd_code), 1);
        cyc(2'b01, 0, 0, 0, 0, "R8 overwrite release");
        chk(pd_code == 6'd2, "R8 newest pending wins", int'(pd_code), 2);
        // R7 R9: pull-up frozen by reserved state and by driving 1
        to_tick(2'b11);
        cyc(2'b11, 0, 1, 0, 0, "R9 tick");
        repeat (4) cyc(2'b11, 0, 0, 0, 0, "R9 hold");
        chk(pu_code == 6'd63, "R9 reserved blocks pu", int'(pu_code), 63);
        cyc(2'b01, 0, 0, 0, 0, "R7 drive1");
        chk(pu_code == 6'd63, "R7 pu held while high", int'(pu_code), 63);
        cyc(2'b00, 0, 0, 0, 0, "R7 release");
        chk(pu_code == 6'd62, "R7 pu applied while low", int'(pu_code), 62);
        // R4: both flags together leave the code alone
        to_tick(2'b10);
        cyc(2'b10, 1, 1, 1, 1, "R4 both");
        chk(pu_code == 6'd62, "R4 both flags pu", int'(pu_code), 62);
        chk(pd_code == 6'd2, "R4 both flags pd", int'(pd_code), 2);
        // random phase, R3 step size checked on every cycle
        for (int k = 0; k < 4000; k++) begin
            prev_pu = int'(pu_code);
            prev_pd = int'(pd_code);
            cyc(2'($urandom % 4), 1'($urandom), 1'($urandom),
                1'($urandom), 1'($urandom), "random");
            chk((int'(pu_code) - prev_pu) <= 1 && (prev_pu - int'(pu_code)) <= 1,
                "R3 pu step", int'(pu_code), prev_pu);
            chk((int'(pd_code) - prev_pd) <= 1 && (prev_pd - int'(pd_code)) <= 1,
                "R3 pd step", int'(pd_code), prev_pd);
        end
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

endmodule